// File: doc/BRIEF.md
# ADC Conversion Schedule Sequencer

This block is the digital controller that drives a 12-bit analog-to-digital converter through a table of sixteen schedule slots. Each slot holds a 4-bit channel code. A 16-bit enable mask picks which slots take part in a pass. The sequencer visits the enabled slots from the lowest index to the highest. For each one it raises a conversion request carrying the slot's channel code, and it collects the 12-bit result returned with a one-cycle done pulse.

Two operating modes are supported. In one-shot mode, a software start pulse or a timer trigger launches a single pass. Results land in per-slot result registers, or in the result FIFO when the redirect input is set, and a pass-done pulse marks the end of the pass. In continuous mode, passes repeat for as long as the enable input stays high, and every result is pushed into a 32-entry FIFO. The FIFO reports its fill level and raises a level-threshold request for a DMA engine.

An optional averager converts each slot 2^k times and reports the truncated mean.

Top module: `adc_sched_seq`

## Requirements
- R1: After reset, conv_req_o, pass_done_o, fifo_ovf_o and dma_req_o are 0, fifo_level_o is 0, fifo_empty_o is 1 and every result register reads 0.
- R2: Slot i takes part only when bitmap_i[i] is 1. Enabled slots are converted in ascending index order. While a slot is being converted, conv_ch_o equals that slot's code, which is held in slot_cfg_i[4*i+3:4*i].
- R3: Channel codes 0 to 7 (external inputs), 8 (battery) and 9 (adapter) are converted. Codes 10 to 15 are skipped and no request is raised for them.
- R4: In one-shot mode (cont_mode_i=0), a start_i or tmr_trig_i pulse seen while idle with en_i=1 launches one pass. At the end of the pass, pass_done_o pulses for exactly one cycle and no further request follows.
- R5: In one-shot mode with to_fifo_i=0, each slot's result is written to its result register, which is read at res_data_o by setting res_slot_i. With to_fifo_i=1, the result is pushed to the FIFO instead and the result registers are left unchanged.
- R6: In continuous mode (cont_mode_i=1 with en_i=1), passes repeat back to back. Every result is pushed to the FIFO as {slot[3:0], result[11:0]}.
- R7: With avg_log2_i=k, each slot is converted 2^k times and the result is (sum of the samples) >> k, kept to 12 bits. Values of k above 8 are treated as 8.
- R8: The FIFO holds 32 entries and returns them in push order at fifo_data_o. A pop while the FIFO is empty is ignored. A push while the FIFO is full is dropped and sets fifo_ovf_o, which stays set until reset.
- R9: dma_req_o is 1 exactly when fifo_level_o is nonzero and fifo_level_o >= fifo_thr_i.
- R10: Driving en_i low stops the sequencer. conv_req_o is 0 from the next cycle, and no pass_done_o pulse follows. A launch with an all-zero bitmap_i leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sequencer enable |
| cont_mode_i | input | 1 | 1 selects continuous mode, 0 selects one-shot mode |
| start_i | input | 1 | Software start pulse for a one-shot pass |
| tmr_trig_i | input | 1 | Timer start pulse for a one-shot pass |
| to_fifo_i | input | 1 | Redirects one-shot results to the FIFO |
| bitmap_i | input | 16 | Slot enable mask |
| slot_cfg_i | input | 64 | Channel codes, 4 bits per slot |
| avg_log2_i | input | 4 | log2 of the averaging count |
| conv_req_o | output | 1 | Conversion request to the converter |
| conv_ch_o | output | 4 | Channel code for the current request |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 12 | Converter result |
| res_slot_i | input | 4 | Result register read select |
| res_data_o | output | 12 | Selected result register |
| pass_done_o | output | 1 | End-of-pass pulse in one-shot mode |
| fifo_pop_i | input | 1 | FIFO pop |
| fifo_data_o | output | 16 | FIFO head entry {slot, result} |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_level_o | output | 6 | FIFO fill level |
| fifo_thr_i | input | 6 | DMA level threshold |
| dma_req_o | output | 1 | DMA request |
| fifo_ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench uses the default parameters: 16 slots, 4-bit codes, 12-bit data, a 32-entry FIFO and an averaging limit of 2^8. With these values, a continuous run of two slots fills and overflows the FIFO within a few hundred cycles. The full 256-sample averaging case, including the clamp of oversized averaging counts, fits inside one test. The converter model answers each request after a fixed latency with data derived from the channel and a sample count. This lets the bench rebuild the expected channel order, averages and FIFO contents from its own record of the samples it supplied.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned CODE_LAST = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_slot_pick.sv
module adc_slot_pick #(
  parameter int unsigned NSLOT = 16,
  parameter int unsigned CW    = adc_sched_pkg::CODE_W,
  localparam int unsigned IW   = $clog2(NSLOT),
  localparam int unsigned PW   = IW + 1
) (
  input  logic [NSLOT-1:0]    bitmap_i,
  input  logic [NSLOT*CW-1:0] codes_i,
  input  logic [PW-1:0]       from_i,
  output logic                found_o,
  output logic [IW-1:0]       idx_o
);
  logic [NSLOT-1:0] code_ok;

  for (genvar g = 0; g < NSLOT; g++) begin : g_ok
    assign code_ok[g] = codes_i[g*CW +: CW] <= CW'(adc_sched_pkg::CODE_LAST);
  end

  // lowest enabled, valid slot at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (PW'(i) >= from_i && bitmap_i[i] && code_ok[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_avg_acc.sv
module adc_avg_acc #(
  parameter int unsigned DW       = 12,
  parameter int unsigned MAX_LOG2 = 8,
  localparam int unsigned AW      = DW + MAX_LOG2,
  localparam int unsigned CNTW    = MAX_LOG2 + 1,
  localparam int unsigned LW      = $clog2(MAX_LOG2 + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          smp_i,
  input  logic [DW-1:0] data_i,
  input  logic [LW-1:0] log2_i,
  output logic          last_o,
  output logic [DW-1:0] avg_o
);
  logic [AW-1:0]   acc_q, sum_nxt;
  logic [CNTW-1:0] cnt_q, cnt_lim;
  logic [LW-1:0]   k;

  assign k       = (log2_i > LW'(MAX_LOG2)) ? LW'(MAX_LOG2) : log2_i;
  assign cnt_lim = ({{(CNTW-1){1'b0}}, 1'b1} << k) - CNTW'(1);
  assign sum_nxt = acc_q + AW'(data_i);
  assign last_o  = smp_i && (cnt_q == cnt_lim);
  assign avg_o   = DW'(sum_nxt >> k);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i || last_o) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (smp_i) begin
      acc_q <= sum_nxt;
      cnt_q <= cnt_q + CNTW'(1);
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= cnt_lim || clr_i || $changed(log2_i) || !$stable(k));
endmodule

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int unsigned WW    = 16,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LVW  = AW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [WW-1:0]  wdata_i,
  input  logic           pop_i,
  output logic [WW-1:0]  rdata_o,
  output logic           empty_o,
  output logic [LVW-1:0] level_o,
  output logic           ovf_o
);
  logic [WW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wp_q, rp_q;
  logic [LVW-1:0] lvl_q;
  logic           ovf_q, full, push_ok, pop_ok;

  assign full    = lvl_q == LVW'(DEPTH);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && lvl_q != '0;
  assign rdata_o = mem[rp_q];
  assign empty_o = lvl_q == '0;
  assign level_o = lvl_q;
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      lvl_q <= lvl_q + LVW'(push_ok) - LVW'(pop_ok);
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  assert_level_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVW'(DEPTH));
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  assert_full_push_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i) |=> (lvl_q == LVW'(DEPTH) && ovf_q));
endmodule

// File: rtl/adc_sched_seq.sv
module adc_sched_seq #(
  parameter int unsigned NSLOT    = 16,
  parameter int unsigned DW       = 12,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned MAX_LOG2 = 8,
  localparam int unsigned CW      = adc_sched_pkg::CODE_W,
  localparam int unsigned IW      = $clog2(NSLOT),
  localparam int unsigned PW      = IW + 1,
  localparam int unsigned LVW     = $clog2(DEPTH) + 1,
  localparam int unsigned LW      = $clog2(MAX_LOG2 + 1),
  localparam int unsigned FW      = IW + DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cont_mode_i,
  input  logic              start_i,
  input  logic              tmr_trig_i,
  input  logic              to_fifo_i,
  input  logic [NSLOT-1:0]  bitmap_i,
  input  logic [NSLOT*CW-1:0] slot_cfg_i,
  input  logic [LW-1:0]     avg_log2_i,
  output logic              conv_req_o,
  output logic [CW-1:0]     conv_ch_o,
  input  logic              conv_done_i,
  input  logic [DW-1:0]     conv_data_i,
  input  logic [IW-1:0]     res_slot_i,
  output logic [DW-1:0]     res_data_o,
  output logic              pass_done_o,
  input  logic              fifo_pop_i,
  output logic [FW-1:0]     fifo_data_o,
  output logic              fifo_empty_o,
  output logic [LVW-1:0]    fifo_level_o,
  input  logic [LVW-1:0]    fifo_thr_i,
  output logic              dma_req_o,
  output logic              fifo_ovf_o
);
  import adc_sched_pkg::*;

  seq_state_e    st_q;
  logic [PW-1:0] ptr_q;
  logic          done_q;
  logic [DW-1:0] res_q [NSLOT];

  logic          found, smp, last, launch, to_fifo, push, wr_reg;
  logic [IW-1:0] pick_idx, cur;
  logic [DW-1:0] avg;
  logic [PW-1:0] ptr_nxt;

  assign cur     = ptr_q[IW-1:0];
  assign smp     = (st_q == ST_CONV) && conv_done_i;
  assign launch  = en_i && (bitmap_i != '0) && (cont_mode_i || start_i || tmr_trig_i);
  assign to_fifo = cont_mode_i || to_fifo_i;
  assign push    = last && to_fifo;
  assign wr_reg  = last && !to_fifo;
  assign ptr_nxt = {1'b0, cur} + PW'(1);

  adc_slot_pick #(.NSLOT(NSLOT), .CW(CW)) u_pick (
    .bitmap_i (bitmap_i),
    .codes_i  (slot_cfg_i),
    .from_i   (ptr_q),
    .found_o  (found),
    .idx_o    (pick_idx)
  );

  adc_avg_acc #(.DW(DW), .MAX_LOG2(MAX_LOG2)) u_avg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_q == ST_SCAN),
    .smp_i  (smp),
    .data_i (conv_data_i),
    .log2_i (avg_log2_i),
    .last_o (last),
    .avg_o  (avg)
  );

  adc_res_fifo #(.WW(FW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i ({cur, avg}),
    .pop_i   (fifo_pop_i),
    .rdata_o (fifo_data_o),
    .empty_o (fifo_empty_o),
    .level_o (fifo_level_o),
    .ovf_o   (fifo_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (launch) begin
            st_q  <= ST_SCAN;
            ptr_q <= '0;
          end
          ST_SCAN: if (found) begin
            st_q  <= ST_CONV;
            ptr_q <= {1'b0, pick_idx};
          end else if (cont_mode_i) begin
            ptr_q <= '0;
          end else begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
          ST_CONV: if (last) begin
            st_q  <= ST_SCAN;
            ptr_q <= ptr_nxt;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSLOT; i++) res_q[i] <= '0;
    end else if (wr_reg) begin
      res_q[cur] <= avg;
    end
  end

  assign conv_req_o  = st_q == ST_CONV;
  assign conv_ch_o   = slot_cfg_i[cur*CW +: CW];
  assign res_data_o  = res_q[res_slot_i];
  assign pass_done_o = done_q;
  assign dma_req_o   = (fifo_level_o != '0) && (fifo_level_o >= fifo_thr_i);

  assert_req_valid_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> (conv_ch_o <= CW'(CODE_LAST)));
  assert_req_slot_enabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> bitmap_i[cur] || $changed(bitmap_i));
  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_done_o |=> !pass_done_o);
  assert_done_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_done_o |-> !conv_req_o);
  assert_disable_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!conv_req_o && !pass_done_o));
  assert_dma_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> !fifo_empty_o);
endmodule

// File: tb/tb_adc_sched_seq.sv
module tb_adc_sched_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0, cont_mode_i = 1'b0, start_i = 1'b0, tmr_trig_i = 1'b0, to_fifo_i = 1'b0;
  logic [15:0] bitmap_i = '0;
  logic [63:0] slot_cfg_i = '0;
  logic [3:0]  avg_log2_i = '0;
  logic        conv_req_o;
  logic [3:0]  conv_ch_o;
  logic        conv_done_i = 1'b0;
  logic [11:0] conv_data_i = '0;
  logic [3:0]  res_slot_i = '0;
  logic [11:0] res_data_o;
  logic        pass_done_o;
  logic        fifo_pop_i = 1'b0;
  logic [15:0] fifo_data_o;
  logic        fifo_empty_o;
  logic [5:0]  fifo_level_o;
  logic [5:0]  fifo_thr_i = 6'd16;
  logic        dma_req_o, fifo_ovf_o;

  int tests = 0, fails = 0, cyc = 0, done_cnt = 0, seq = 0;
  logic [3:0]  rec_ch [$];
  logic [11:0] rec_dt [$];

  always #4 clk_i = ~clk_i;

  adc_sched_seq dut (.*);

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: fixed 2-cycle latency
  initial forever begin
    @(negedge clk_i);
    if (conv_req_o) begin
      logic [3:0] ch;
      ch = conv_ch_o;
      repeat (2) @(negedge clk_i);
      conv_data_i = 12'((int'(ch) * 613 + seq * 97 + 5) % 4096);
      seq++;
      rec_ch.push_back(ch);
      rec_dt.push_back(conv_data_i);
      conv_done_i = 1'b1;
      @(negedge clk_i);
      conv_done_i = 1'b0;
    end
  end

  // per-clock checks
  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni) begin
      if (pass_done_o) done_cnt++;
      if (dma_req_o !== ((fifo_level_o != 0) && (fifo_level_o >= fifo_thr_i)))
        chk("R9 dma_req", int'(dma_req_o), int'(!dma_req_o));
      if (fifo_level_o > 32) chk("R8 level", int'(fifo_level_o), 32);
    end
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pulse_start(bit tmr);
    @(negedge clk_i);
    if (tmr) tmr_trig_i = 1'b1; else start_i = 1'b1;
    @(negedge clk_i);
    tmr_trig_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic wait_pass(int d0);
    int n = 0;
    while (done_cnt == d0 && n < 5000) begin @(negedge clk_i); n++; end
    repeat (4) @(negedge clk_i);
  endtask

  function automatic int avg_of(int from, int n, int k);
    int s = 0;
    for (int i = from; i < from + n; i++) s += int'(rec_dt[i]);
    return (s >> k) & 12'hFFF;
  endfunction

  initial begin
    int d0, r0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 req", int'(conv_req_o), 0);
    chk("R1 done", int'(pass_done_o), 0);
    chk("R1 empty", int'(fifo_empty_o), 1);
    chk("R1 level", int'(fifo_level_o), 0);
    chk("R1 ovf", int'(fifo_ovf_o), 0);
    chk("R1 res", int'(res_data_o), 0);
    rst_ni = 1'b1;
    en_i = 1'b1;

    // R2 R4 R5: one-shot, bitmap 0x0005, slot0=3 slot2=8
    bitmap_i = 16'h0005;
    slot_cfg_i = '0; slot_cfg_i[3:0] = 4'd3; slot_cfg_i[11:8] = 4'd8; slot_cfg_i[7:4] = 4'd1;
    rec_ch.delete(); rec_dt.delete();
    d0 = done_cnt;
    pulse_start(0);
    wait_pass(d0);
    chk("R4 one pass_done", done_cnt - d0, 1);
    chk("R2 count", rec_ch.size(), 2);
    if (rec_ch.size() == 2) begin
      chk("R2 first ch", int'(rec_ch[0]), 3);
      chk("R2 second ch", int'(rec_ch[1]), 8);
      res_slot_i = 4'd0; #1;
      chk("R5 res slot0", int'(res_data_o), int'(rec_dt[0]));
      res_slot_i = 4'd2; #1;
      chk("R5 res slot2", int'(res_data_o), int'(rec_dt[1]));
      res_slot_i = 4'd1; #1;
      chk("R2 res slot1 untouched", int'(res_data_o), 0);
    end
    r0 = rec_dt.size() > 0 ? int'(rec_dt[0]) : -1;
    repeat (20) @(negedge clk_i);
    chk("R4 idle after pass", int'(conv_req_o), 0);

    // R3: slot1 code 12 skipped, slot3 code 9
    bitmap_i = 16'h000B;
    slot_cfg_i = '0; slot_cfg_i[3:0] = 4'd3; slot_cfg_i[7:4] = 4'd12; slot_cfg_i[15:12] = 4'd9;
    rec_ch.delete(); rec_dt.delete();
    d0 = done_cnt;
    pulse_start(0);
    wait_pass(d0);
    chk("R3 count", rec_ch.size(), 2);
    if (rec_ch.size() == 2) begin
      chk("R3 ch a", int'(rec_ch[0]), 3);
      chk("R3 ch b", int'(rec_ch[1]), 9);
    end
    res_slot_i = 4'd0; #1;
    r0 = int'(res_data_o);

    // R4 timer + R5 fifo redirect + R7 averaging k=2
    bitmap_i = 16'h0001; slot_cfg_i = '0; slot_cfg_i[3:0] = 4'd5;
    to_fifo_i = 1'b1; avg_log2_i = 4'd2;
    rec_ch.delete(); rec_dt.delete();
    d0 = done_cnt;
    pulse_start(1);
    wait_pass(d0);
    chk("R4 timer pass", done_cnt - d0, 1);
    chk("R7 samples k2", rec_dt.size(), 4);
    chk("R5 fifo level", int'(fifo_level_o), 1);
    if (rec_dt.size() == 4)
      chk("R7 avg k2 in fifo", int'(fifo_data_o), avg_of(0, 4, 2));
    res_slot_i = 4'd0; #1;
    chk("R5 res unchanged", int'(res_data_o), r0);
    fifo_pop_i = 1'b1; @(negedge clk_i); fifo_pop_i = 1'b0;
    chk("R8 pop empty", int'(fifo_empty_o), 1);
    fifo_pop_i = 1'b1; @(negedge clk_i); fifo_pop_i = 1'b0;
    chk("R8 pop when empty ignored", int'(fifo_level_o), 0);

    // R7 clamp k=12 -> 256 samples
    to_fifo_i = 1'b0; avg_log2_i = 4'd12;
    rec_ch.delete(); rec_dt.delete();
    d0 = done_cnt;
    pulse_start(0);
    wait_pass(d0);
    chk("R7 clamp samples", rec_dt.size(), 256);
    if (rec_dt.size() == 256) chk("R7 clamp avg", int'(res_data_o), avg_of(0, 256, 8));
    avg_log2_i = 4'd0;

    // R10: zero bitmap stays idle
    bitmap_i = '0;
    d0 = done_cnt;
    pulse_start(0);
    repeat (20) @(negedge clk_i);
    chk("R10 zero bitmap req", int'(conv_req_o), 0);
    chk("R10 zero bitmap done", done_cnt - d0, 0);

    // R6 R8 R9: continuous, slot0=0 slot15=1, overflow
    bitmap_i = 16'h8001; slot_cfg_i = '0; slot_cfg_i[63:60] = 4'd1;
    rec_ch.delete(); rec_dt.delete();
    cont_mode_i = 1'b1;
    while (rec_dt.size() < 36) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R10 req off", int'(conv_req_o), 0);
    repeat (6) @(negedge clk_i);
    cont_mode_i = 1'b0;
    chk("R8 full level", int'(fifo_level_o), 32);
    chk("R8 ovf set", int'(fifo_ovf_o), 1);
    chk("R9 dma_req", int'(dma_req_o), 1);
    for (int i = 0; i < 32; i++) begin
      int exp;
      exp = ((rec_ch[i] == 4'd0 ? 0 : 15) << 12) | int'(rec_dt[i]);
      chk("R6 fifo order", int'(fifo_data_o), exp);
      if (i < 2) chk("R6 alternating ch", int'(rec_ch[i]), i);
      fifo_pop_i = 1'b1; @(negedge clk_i); fifo_pop_i = 1'b0;
    end
    chk("R8 drained", int'(fifo_empty_o), 1);
    chk("R8 ovf sticky", int'(fifo_ovf_o), 1);
    chk("R9 no dma empty", int'(dma_req_o), 0);

    // R10 abort mid pass
    en_i = 1'b1; avg_log2_i = 4'd8; bitmap_i = 16'h0001; slot_cfg_i = '0;
    repeat (4) @(negedge clk_i);
    d0 = done_cnt;
    pulse_start(0);
    repeat (30) @(negedge clk_i);
    chk("R10 busy before abort", int'(conv_req_o), 1);
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R10 abort req", int'(conv_req_o), 0);
    repeat (100) @(negedge clk_i);
    chk("R10 abort no done", done_cnt - d0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule